// File: doc/BRIEF.md
# Latency-Insensitive Core Shell

This block wraps an unmodified synchronous core so that the core can be joined to other blocks through chains of relay stations whose length is unknown when the core is designed. Every input channel carries a data word, a void flag that marks the word as empty, and a stop flag that the shell returns upstream. Every output channel carries a data word and a void flag, and takes a stop flag from downstream.

Each input channel has a two-entry queue. Tokens can arrive on different cycles, and the queues line them up. The core may compute only when every queue holds a token and no output channel is being stopped. The shell then raises a synchronous clock-enable for one cycle, removes one token from every queue, and marks the core results non-void on the following cycle. At all other times the enable is low and the core holds its state. An input's stop is raised while its queue is full. An output that is stopped keeps its token until downstream releases it.

Top module: `lis_shell`

## Requirements
- R1: After a synchronous reset every queue is empty, every `outVoid` bit is 1, every `stopOut` bit is 0 and `coreEn` is 0.
- R2: A token is written into channel i's queue at a clock edge where `inVoid[i]` is 0 and `stopOut[i]` is 0. Each queue is first-in first-out.
- R3: `stopOut[i]` is 1 exactly when channel i's queue holds two tokens. A token offered while `stopOut[i]` is 1 is not taken.
- R4: `coreEn` is 1 exactly when every input queue holds at least one token and every `stopIn` bit is 0.
- R5: While `coreEn` is 1, slice i of `coreArgs` (bits i*WIDTH and up) holds the oldest token of queue i. At that edge one token is removed from every queue.
- R6: In the cycle after a cycle with `coreEn` at 1, every `outVoid` bit is 0. Slice j of `outData` is slice j of `coreRes`. An output that is neither launched nor held is void.
- R7: If output j is non-void and `stopIn[j]` is 1, then in the next cycle output j is still non-void and its data is unchanged.
- R8: When tokens reach an empty shell on all inputs at the same edge, `coreEn` is 1 in the cycle after that edge, and the outputs are non-void one cycle later.
- R9: The k-th token delivered on every output is computed from the k-th token accepted on every input, whatever the relative arrival times of those tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | NUM_IN*WIDTH | Input channel data words, channel i at bits i*WIDTH and up |
| inVoid | input | NUM_IN | 1 marks the input channel word as empty |
| stopOut | output | NUM_IN | Backpressure to each upstream channel |
| coreEn | output | 1 | Synchronous clock-enable for the wrapped core |
| coreArgs | output | NUM_IN*WIDTH | Queue heads presented to the core |
| coreRes | input | NUM_OUT*WIDTH | Registered results from the core |
| outData | output | NUM_OUT*WIDTH | Output channel data words |
| outVoid | output | NUM_OUT | 1 marks the output channel word as empty |
| stopIn | input | NUM_OUT | Backpressure from each downstream channel |

## Verification
The bench offers a third token to a queue that is already full. A shell that overwrote a slot or advanced its count would shift every later result. It also stalls one input while the other runs ahead. A shell that fired on a partial set of tokens would pair the k-th token of one input with a later token of the other. Downstream stop is asserted on a valid output. A shell that dropped the token, or that let the core fire under stop, would lose results or change a held word. A bench model of queue occupancy predicts `coreEn` and `stopOut` on every cycle, so a queue full or empty test that is off by one shows up at once.

// File: rtl/lis_pkg.sv
package lis_pkg;
  typedef struct packed {
    logic pop;     // remove one token from every input queue
    logic launch;  // mark all outputs non-void next cycle
  } lis_strobe_t;
endpackage

// File: rtl/lis_control.sv
module lis_control #(
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 2
) (
  input  logic [NUM_IN-1:0]  hasToken,
  input  logic [NUM_OUT-1:0] stopIn,
  output logic               coreEn,
  output lis_pkg::lis_strobe_t strobes
);
  logic fire;

  always_comb begin
    fire           = (&hasToken) && !(|stopIn);
    coreEn         = fire;
    strobes.pop    = fire;
    strobes.launch = fire;
  end
endmodule

// File: rtl/lis_datapath.sv
module lis_datapath #(
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 2,
  parameter int WIDTH   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN*WIDTH-1:0]  inData,
  input  logic [NUM_IN-1:0]        inVoid,
  output logic [NUM_IN-1:0]        stopOut,
  output logic [NUM_IN-1:0]        hasToken,
  output logic [NUM_IN*WIDTH-1:0]  coreArgs,
  input  lis_pkg::lis_strobe_t     strobes,
  input  logic [NUM_OUT-1:0]       stopIn,
  output logic [NUM_OUT-1:0]       outVoid
);
  localparam int DEPTH = 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_queue
    logic [WIDTH-1:0] slotHead;
    logic [WIDTH-1:0] slotTail;
    logic [CNT_W-1:0] fill;
    logic             full;
    logic             push;
    logic [WIDTH-1:0] word;

    assign word = inData[i*WIDTH +: WIDTH];
    assign full = (fill == CNT_W'(DEPTH));
    assign push = !inVoid[i] && !full;

    always_ff @(posedge clk) begin
      if (rst) begin
        fill     <= '0;
        slotHead <= '0;
        slotTail <= '0;
      end else begin
        case ({push, strobes.pop})
          2'b10: begin
            if (fill == '0) slotHead <= word;
            else            slotTail <= word;
            fill <= fill + 1'b1;
          end
          2'b01: begin
            slotHead <= slotTail;
            fill     <= fill - 1'b1;
          end
          2'b11: begin
            // pop with room to push implies a single held token
            slotHead <= word;
          end
          default: ;
        endcase
      end
    end

    assign stopOut[i]               = full;
    assign hasToken[i]              = (fill != '0);
    assign coreArgs[i*WIDTH +: WIDTH] = slotHead;
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic live;
    always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= strobes.launch || (live && stopIn[j]);
    end
    assign outVoid[j] = !live;
  end
endmodule

// File: rtl/lis_shell.sv
module lis_shell #(
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 2,
  parameter int WIDTH   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN*WIDTH-1:0]   inData,
  input  logic [NUM_IN-1:0]         inVoid,
  output logic [NUM_IN-1:0]         stopOut,
  output logic                      coreEn,
  output logic [NUM_IN*WIDTH-1:0]   coreArgs,
  input  logic [NUM_OUT*WIDTH-1:0]  coreRes,
  output logic [NUM_OUT*WIDTH-1:0]  outData,
  output logic [NUM_OUT-1:0]        outVoid,
  input  logic [NUM_OUT-1:0]        stopIn
);
  lis_pkg::lis_strobe_t strobes;
  logic [NUM_IN-1:0]    hasToken;

  lis_control #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_ctrl (
    .hasToken(hasToken),
    .stopIn  (stopIn),
    .coreEn  (coreEn),
    .strobes (strobes)
  );

  lis_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .inVoid  (inVoid),
    .stopOut (stopOut),
    .hasToken(hasToken),
    .coreArgs(coreArgs),
    .strobes (strobes),
    .stopIn  (stopIn),
    .outVoid (outVoid)
  );

  assign outData = coreRes;
endmodule

// File: rtl/lis_shell_chk.sv
module lis_shell_chk #(
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 2,
  parameter int WIDTH   = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_IN-1:0]        inVoid,
  input logic [NUM_IN-1:0]        stopOut,
  input logic                     coreEn,
  input logic [NUM_OUT*WIDTH-1:0] outData,
  input logic [NUM_OUT-1:0]       outVoid,
  input logic [NUM_OUT-1:0]       stopIn
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> ((&outVoid) && (stopOut == '0)));

  // R4
  no_fire_under_stop_chk: assert property (@(posedge clk) disable iff (rst)
    coreEn |-> (stopIn == '0));

  // R6
  launch_nonvoid_chk: assert property (@(posedge clk) disable iff (rst)
    coreEn |=> (outVoid == '0));

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_hold
    // R7
    held_token_chk: assert property (@(posedge clk) disable iff (rst)
      (!outVoid[j] && stopIn[j]) |=>
        (!outVoid[j] && $stable(outData[j*WIDTH +: WIDTH])));
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_fill
    // R3
    full_needs_push_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(stopOut[i]) |-> $past(!inVoid[i]));
  end
endmodule

bind lis_shell lis_shell_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .inVoid (inVoid),
  .stopOut(stopOut),
  .coreEn (coreEn),
  .outData(outData),
  .outVoid(outVoid),
  .stopIn (stopIn)
);

// File: tb/lis_shell_test.sv
module lis_shell_test;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int W  = 8;
  localparam int MAXTOK = 8192;

  logic clk = 0;
  logic rst = 1;
  logic [NI*W-1:0] inData = '0;
  logic [NI-1:0]   inVoid = '1;
  logic [NI-1:0]   stopOut;
  logic            coreEn;
  logic [NI*W-1:0] coreArgs;
  logic [NO*W-1:0] coreRes;
  logic [NO*W-1:0] outData;
  logic [NO-1:0]   outVoid;
  logic [NO-1:0]   stopIn = '0;

  always #4 clk = ~clk;

  lis_shell #(.NUM_IN(NI), .NUM_OUT(NO), .WIDTH(W)) uut (
    .clk(clk), .rst(rst), .inData(inData), .inVoid(inVoid), .stopOut(stopOut),
    .coreEn(coreEn), .coreArgs(coreArgs), .coreRes(coreRes),
    .outData(outData), .outVoid(outVoid), .stopIn(stopIn)
  );

  // Bench core: out0 = a + b, out1 = a ^ b, registered under enable
  logic [W-1:0] res0 = '0, res1 = '0;
  always_ff @(posedge clk) begin
    if (coreEn) begin
      res0 <= coreArgs[0 +: W] + coreArgs[W +: W];
      res1 <= coreArgs[0 +: W] ^ coreArgs[W +: W];
    end
  end
  assign coreRes = {res1, res0};

  function automatic logic [W-1:0] coreFn(int j, logic [W-1:0] a, logic [W-1:0] b);
    return (j == 0) ? W'(a + b) : (a ^ b);
  endfunction

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [W-1:0] tok [NI][MAXTOK];
  int  pushed [NI];
  int  fires = 0;
  int  rd [NO];
  bit  expValid [NO];
  bit  heldPrev [NO];
  logic [W-1:0] lastData [NO];
  bit  dV [NI];
  logic [W-1:0] dD [NI];
  bit  dS [NO];
  bit  taken [NI];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit expFire;
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      inVoid[i] = !dV[i];
      inData[i*W +: W] = dD[i];
    end
    for (int j = 0; j < NO; j++) stopIn[j] = dS[j];
    #1;
    expFire = 1;
    for (int i = 0; i < NI; i++) if (pushed[i] - fires == 0) expFire = 0;
    for (int j = 0; j < NO; j++) if (dS[j]) expFire = 0;
    check(coreEn == expFire, "R4 coreEn", coreEn, expFire);
    for (int i = 0; i < NI; i++) begin
      check(stopOut[i] == (pushed[i] - fires == 2), "R3 stopOut", stopOut[i],
            (pushed[i] - fires == 2));
      if (expFire)
        check(coreArgs[i*W +: W] == tok[i][fires], "R5 coreArgs",
              coreArgs[i*W +: W], tok[i][fires]);
    end
    for (int j = 0; j < NO; j++) begin
      check(outVoid[j] == !expValid[j], "R6 outVoid", outVoid[j], !expValid[j]);
      if (expValid[j] && heldPrev[j])
        check(outData[j*W +: W] == lastData[j], "R7 held data",
              outData[j*W +: W], lastData[j]);
      if (expValid[j] && !dS[j]) begin
        check(outData[j*W +: W] == coreFn(j, tok[0][rd[j]], tok[1][rd[j]]),
              "R9 result", outData[j*W +: W], coreFn(j, tok[0][rd[j]], tok[1][rd[j]]));
        rd[j]++;
      end
    end
    for (int j = 0; j < NO; j++) begin
      heldPrev[j] = expValid[j] && dS[j];
      lastData[j] = outData[j*W +: W];
      expValid[j] = expFire || (expValid[j] && dS[j]);
    end
    for (int i = 0; i < NI; i++) begin
      taken[i] = dV[i] && !stopOut[i];   // R2 accept rule
      if (taken[i]) begin
        tok[i][pushed[i]] = dD[i];
        pushed[i]++;
      end
    end
    if (expFire) fires++;
  endtask

  task automatic idle();
    for (int i = 0; i < NI; i++) dV[i] = 0;
    for (int j = 0; j < NO; j++) dS[j] = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NI; i++) begin pushed[i] = 0; dV[i] = 0; dD[i] = '0; taken[i] = 0; end
    for (int j = 0; j < NO; j++) begin rd[j] = 0; expValid[j] = 0; heldPrev[j] = 0; dS[j] = 0; lastData[j] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outVoid == '1, "R1 outVoid", outVoid, 3);
    check(stopOut == '0, "R1 stopOut", stopOut, 0);
    check(coreEn == 0, "R1 coreEn", coreEn, 0);
    rst = 0;

    // R8 latency into an empty shell, then R7 hold on output 0
    dV[0] = 1; dD[0] = 8'h11; dV[1] = 1; dD[1] = 8'h22; step();
    idle(); step();
    check(coreEn == 1, "R8 fire next cycle", coreEn, 1);
    dS[0] = 1; step();
    check(outVoid == '0, "R8 outputs valid", outVoid, 0);
    step();
    check(outVoid[0] == 0 && outData[0 +: W] == 8'h33, "R7 held output", outData[0 +: W], 8'h33);
    idle(); step();

    // R3 fill input 0 while input 1 is void; third token must be refused
    dV[0] = 1; dD[0] = 8'hA1; step();
    dD[0] = 8'hA2; step();
    dD[0] = 8'hA3; step();
    check(stopOut[0] == 1, "R3 full stop", stopOut[0], 1);
    check(coreEn == 0, "R4 starved input", coreEn, 0);
    // R9 input 1 arrives late; results pair A1/A2 with these
    dV[0] = 0; dV[1] = 1; dD[1] = 8'h05; step();
    dD[1] = 8'h06; step();
    idle(); repeat (4) step();
    check(rd[0] == 3 && rd[1] == 3, "R9 delivered count", rd[0], 3);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NI; i++)
        if (!dV[i] || taken[i]) begin
          dV[i] = (($urandom % 100) < 60);
          dD[i] = W'($urandom);
        end
      for (int j = 0; j < NO; j++) dS[j] = (($urandom % 100) < 25);
      step();
    end
    idle(); repeat (8) step();
    check(rd[0] == fires && rd[1] == fires, "R9 all delivered", rd[0], fires);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule